// File: doc/BRIEF.md
# Dual-Clock Replay FIFO

This block moves 36-bit words from a write port to a read port. Each port has its own free-running clock, and the two clocks may be unrelated or may be the same clock. Storage is a 2048-word dual-port array. The write side reports whether it can take a word (`inReady`) and whether space is running low (`almostFull`). The read side presents the oldest word directly on its output, flagged by `outReady`, and reports when few words remain (`almostEmpty`). Each status flag is formed in its own port's clock domain from a pointer that crosses in Gray code through two flip-flops.

A replay feature lets the reader go back over data it has already consumed. While `rtHold` is low, a saved mark follows the read head. Raising `rtHold` freezes the mark. A one-cycle `rtReplay` pulse then moves the read pointer back to the mark. The write side measures its free space from the mark rather than from the read head, so a held frame cannot be overwritten before it is replayed.

The two threshold offsets reset to 8. They can be changed at run time from the write port, either as a parallel word or by shifting bits in through a one-bit serial input.

Top module: `xclk_replay_fifo`

## Requirements
- R1: While `rstN` is low, `inReady` and `outReady` are 0, `almostEmpty` is 1 and `almostFull` is 0. After `rstN` rises, `inReady` stays 0 until two write-clock edges have passed, and both pointers start from zero.
- R2: Every accepted word is delivered on `rdData` unchanged and in the order it was written.
- R3: A word is accepted on a rising `wrClk` edge only when `wrEn` and `inReady` are both 1. `inReady` falls once 2048 words are held counting from the mark, and any word offered while `inReady` is 0 is dropped.
- R4: `outReady` is 1 exactly when a valid word is on `rdData`. A rising `rdClk` edge with `rdEn` high consumes that word. `rdEn` while `outReady` is 0 has no effect.
- R5: `almostFull` is 1 when the free space (2048 minus the words held from the mark) is less than or equal to the almost-full offset.
- R6: `almostEmpty` is 1 when the number of unread words, including the word on the output, is less than or equal to the almost-empty offset.
- R7: A `wrClk` edge with `cfgWrite` high loads `wrData[10:0]` into the almost-empty offset when `cfgSel` is 0, or into the almost-full offset when `cfgSel` is 1. No word is stored on that edge, even if `wrEn` is high.
- R8: Each `wrClk` edge with `serEn` high (and `cfgWrite` low) shifts `serIn` into the LSB of the 22-bit chain {almost-full offset, almost-empty offset}. After 22 shifts, the first bit sent is bit 10 of the almost-full offset and the last bit sent is bit 0 of the almost-empty offset.
- R9: When no offset has been loaded, both offsets are 8.
- R10: While `rtHold` is 1 the mark is frozen. An `rdClk` edge with `rtReplay` high sets the read pointer to the mark and clears `outReady`. The words from the mark onward are then delivered again in their original order.
- R11: While the mark is held, words that have already been read still count as occupied on the write side, so at most 2048 words can be held counting from the mark.
- R12: A word written into an empty FIFO raises `outReady` no sooner than 2 and no later than 6 read-clock cycles after its write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-port clock |
| rdClk | input | 1 | Read-port clock |
| rstN | input | 1 | Asynchronous reset, active low, synchronised into each domain |
| wrEn | input | 1 | Write enable |
| wrData | input | 36 | Write data; bits 10:0 also carry a parallel offset value |
| cfgWrite | input | 1 | Parallel offset load strobe |
| cfgSel | input | 1 | Offset select for a parallel load: 0 almost-empty, 1 almost-full |
| serEn | input | 1 | Serial offset shift enable |
| serIn | input | 1 | Serial offset data bit |
| inReady | output | 1 | FIFO can accept a word (write domain) |
| almostFull | output | 1 | Free space at or below the almost-full offset (write domain) |
| rdEn | input | 1 | Consume the word shown on rdData |
| rtHold | input | 1 | Freeze the replay mark |
| rtReplay | input | 1 | Rewind the read pointer to the mark |
| rdData | output | 36 | Word at the head of the FIFO |
| outReady | output | 1 | rdData holds a valid word (read domain) |
| almostEmpty | output | 1 | Unread words at or below the almost-empty offset (read domain) |

## Verification
Results in a port's own domain are due one edge after the stimulus. Examples are the output advancing after a consuming `rdEn` edge, or `outReady` clearing after `rtReplay`, and the bench samples these at the next falling edge of that clock. Flags that depend on the other side need one source-clock edge for the Gray register, two destination edges to synchronise and one more to load. The bench therefore checks those flags only after both ports have been idle for ten cycles of each clock. The single exception is a direct count of the delay from a write into an empty FIFO to `outReady`, which is checked against the window of 2 to 6 read cycles. Offset changes cross to the read side through two registers and are likewise checked only after that idle period.

// File: rtl/fifo_pkg.sv
package fifo_pkg;

  // Per-cycle strobes from the control to the storage datapath.
  typedef struct packed {
    logic memWrite;  // write-clock domain: store wrData at wrAddr
    logic outLoad;   // read-clock domain: load rdData from rdAddr
  } dpStrobe_t;

  localparam logic SEL_EMPTY_OFF = 1'b0;
  localparam logic SEL_FULL_OFF  = 1'b1;

endpackage

// File: rtl/fifo_ptr_sync.sv
module fifo_ptr_sync #(
  parameter int W      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] grayIn,
  output logic [W-1:0] binOut
);

  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= '0;
    end else begin
      stage[0] <= grayIn;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  // Gray to binary: bit i is the XOR of all gray bits at or above i.
  always_comb begin
    for (int i = 0; i < W; i++) binOut[i] = ^(stage[STAGES-1] >> i);
  end

endmodule

// File: rtl/fifo_store.sv
module fifo_store
  import fifo_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 11
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobe.memWrite) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk) begin
    if (strobe.outLoad) rdData <= mem[rdAddr];
  end

endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
  import fifo_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int DEF_OFF = 8,
  parameter int SYNC_N  = 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  // write domain
  input  logic              wrEn,
  input  logic              cfgWrite,
  input  logic              cfgSel,
  input  logic [ADDR_W-1:0] cfgValue,
  input  logic              serEn,
  input  logic              serIn,
  output logic              inReady,
  output logic              almostFull,
  // read domain
  input  logic              rdEn,
  input  logic              rtHold,
  input  logic              rtReplay,
  output logic              outReady,
  output logic              almostEmpty,
  // datapath
  output dpStrobe_t         strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr
);

  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0]     DEPTH_P = {1'b1, {ADDR_W{1'b0}}};
  localparam logic [PW-1:0]     ONE_P   = {{ADDR_W{1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] DEF_V   = ADDR_W'(DEF_OFF);

  // ---------------- write clock domain ----------------
  logic [1:0]        wrRstSync;
  logic              wrLive;
  logic [PW-1:0]     wrPtr, wrGray, markBinW, wrUsed, wrFree;
  logic [ADDR_W-1:0] afOff, aeOff;
  logic              doWrite;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) wrRstSync <= '0;
    else       wrRstSync <= {wrRstSync[0], 1'b1};
  end
  assign wrLive = wrRstSync[1];

  assign wrUsed     = wrPtr - markBinW;
  assign wrFree     = DEPTH_P - wrUsed;
  assign inReady    = wrLive && (wrUsed != DEPTH_P);
  assign almostFull = wrLive && (wrFree <= {1'b0, afOff});
  assign doWrite    = wrEn && inReady && !cfgWrite;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      wrGray <= '0;
    end else begin
      if (doWrite) wrPtr <= wrPtr + ONE_P;
      wrGray <= wrPtr ^ (wrPtr >> 1);
    end
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      afOff <= DEF_V;
      aeOff <= DEF_V;
    end else if (wrLive) begin
      if (cfgWrite) begin
        if (cfgSel == SEL_FULL_OFF) afOff <= cfgValue;
        else                        aeOff <= cfgValue;
      end else if (serEn) begin
        {afOff, aeOff} <= {afOff[ADDR_W-2:0], aeOff, serIn};
      end
    end
  end

  // ---------------- read clock domain ----------------
  logic [1:0]        rdRstSync;
  logic              rdLive;
  logic [PW-1:0]     rdPtr, markPtr, markGray, wrBinR, head, rdStored;
  logic [ADDR_W-1:0] aeMeta, aeSync;
  logic              dataAvail, outLoad;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) rdRstSync <= '0;
    else       rdRstSync <= {rdRstSync[0], 1'b1};
  end
  assign rdLive = rdRstSync[1];

  assign head        = rdPtr - {{ADDR_W{1'b0}}, outReady};
  assign dataAvail   = (wrBinR != rdPtr);
  assign outLoad     = rdLive && !rtReplay && dataAvail && (!outReady || rdEn);
  assign rdStored    = wrBinR - head;
  assign almostEmpty = !rdLive || (rdStored <= {1'b0, aeSync});

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdPtr    <= '0;
      outReady <= 1'b0;
      markPtr  <= '0;
      markGray <= '0;
    end else if (rdLive) begin
      if (rtReplay) begin
        rdPtr    <= markPtr;
        outReady <= 1'b0;
      end else if (outLoad) begin
        rdPtr    <= rdPtr + ONE_P;
        outReady <= 1'b1;
      end else if (rdEn) begin
        outReady <= 1'b0;
      end
      if (!rtHold) markPtr <= head;
      markGray <= markPtr ^ (markPtr >> 1);
    end
  end

  // Offsets are quasi-static; the almost-empty one is re-registered here.
  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      aeMeta <= DEF_V;
      aeSync <= DEF_V;
    end else begin
      aeMeta <= aeOff;
      aeSync <= aeMeta;
    end
  end

  // ---------------- pointer crossings ----------------
  fifo_ptr_sync #(.W(PW), .STAGES(SYNC_N)) i_wrToRd (
    .clk   (rdClk),
    .rstN  (rstN),
    .grayIn(wrGray),
    .binOut(wrBinR)
  );

  fifo_ptr_sync #(.W(PW), .STAGES(SYNC_N)) i_markToWr (
    .clk   (wrClk),
    .rstN  (rstN),
    .grayIn(markGray),
    .binOut(markBinW)
  );

  assign strobe.memWrite = doWrite;
  assign strobe.outLoad  = outLoad;
  assign wrAddr          = wrPtr[ADDR_W-1:0];
  assign rdAddr          = rdPtr[ADDR_W-1:0];

  // ---------------- assertions ----------------
  AST_NO_OVERFLOW: assert property (@(posedge wrClk) disable iff (!wrLive)
    wrUsed <= DEPTH_P);  // R3

  AST_FULL_BLOCKS: assert property (@(posedge wrClk) disable iff (!wrLive)
    !inReady |=> $stable(wrPtr));  // R3

  AST_WR_STEP: assert property (@(posedge wrClk) disable iff (!wrLive)
    (wrPtr != $past(wrPtr)) |-> (wrPtr == $past(wrPtr) + ONE_P));  // R2

  AST_CFG_NOSTORE: assert property (@(posedge wrClk) disable iff (!wrLive)
    cfgWrite |=> $stable(wrPtr));  // R7

  AST_RD_MOVE: assert property (@(posedge rdClk) disable iff (!rdLive)
    (rdPtr != $past(rdPtr)) |-> ((rdPtr == $past(rdPtr) + ONE_P) || $past(rtReplay)));  // R10

  AST_RD_BOUND: assert property (@(posedge rdClk) disable iff (!rdLive)
    (wrBinR - rdPtr) <= DEPTH_P);  // R2

  AST_REPLAY_DROP: assert property (@(posedge rdClk) disable iff (!rdLive)
    rtReplay |=> !outReady);  // R10

  AST_MARK_FROZEN: assert property (@(posedge rdClk) disable iff (!rdLive)
    rtHold |=> $stable(markPtr));  // R11

endmodule

// File: rtl/xclk_replay_fifo.sv
module xclk_replay_fifo
  import fifo_pkg::*;
#(
  parameter int DATA_W  = 36,
  parameter int ADDR_W  = 11,
  parameter int DEF_OFF = 8
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cfgWrite,
  input  logic              cfgSel,
  input  logic              serEn,
  input  logic              serIn,
  output logic              inReady,
  output logic              almostFull,
  input  logic              rdEn,
  input  logic              rtHold,
  input  logic              rtReplay,
  output logic [DATA_W-1:0] rdData,
  output logic              outReady,
  output logic              almostEmpty
);

  dpStrobe_t         strobe;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  fifo_ctrl #(.ADDR_W(ADDR_W), .DEF_OFF(DEF_OFF), .SYNC_N(2)) i_ctrl (
    .wrClk      (wrClk),
    .rdClk      (rdClk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .cfgWrite   (cfgWrite),
    .cfgSel     (cfgSel),
    .cfgValue   (wrData[ADDR_W-1:0]),
    .serEn      (serEn),
    .serIn      (serIn),
    .inReady    (inReady),
    .almostFull (almostFull),
    .rdEn       (rdEn),
    .rtHold     (rtHold),
    .rtReplay   (rtReplay),
    .outReady   (outReady),
    .almostEmpty(almostEmpty),
    .strobe     (strobe),
    .wrAddr     (wrAddr),
    .rdAddr     (rdAddr)
  );

  fifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_store (
    .wrClk (wrClk),
    .rdClk (rdClk),
    .strobe(strobe),
    .wrAddr(wrAddr),
    .rdAddr(rdAddr),
    .wrData(wrData),
    .rdData(rdData)
  );

  AST_OUT_HOLD: assert property (@(posedge rdClk) disable iff (!rstN)
    (outReady && !rdEn && !rtReplay) |=> (outReady && $stable(rdData)));  // R4

endmodule

// File: tb/test_xclk_replay_fifo.sv
module test_xclk_replay_fifo;

  localparam int DW = 36;
  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;

  logic wrClk = 0, rdClk = 0, rstN = 0;
  logic wrEn = 0, cfgWrite = 0, cfgSel = 0, serEn = 0, serIn = 0;
  logic rdEn = 0, rtHold = 0, rtReplay = 0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic inReady, almostFull, outReady, almostEmpty;

  always #2.5 wrClk = ~wrClk;  // 200 MHz
  always #3.5 rdClk = ~rdClk;

  xclk_replay_fifo i_xclk_replay_fifo (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEn(wrEn), .wrData(wrData), .cfgWrite(cfgWrite), .cfgSel(cfgSel),
    .serEn(serEn), .serIn(serIn), .inReady(inReady), .almostFull(almostFull),
    .rdEn(rdEn), .rtHold(rtHold), .rtReplay(rtReplay),
    .rdData(rdData), .outReady(outReady), .almostEmpty(almostEmpty)
  );

  int errs = 0, checks = 0;
  logic [DW-1:0] wlog [8192];
  int wrIdx = 0, rdIdx = 0, markIdx = 0;
  bit holdM = 0, finished = 0;
  int afM = 8, aeM = 8;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd36();
    return {$urandom, $urandom};
  endfunction

  function automatic bit expAf(int freeWords);
    return freeWords <= afM;
  endfunction

  function automatic bit expAe(int stored);
    return stored <= aeM;
  endfunction

  task automatic settle();
    wrEn = 0; rdEn = 0;
    repeat (10) @(negedge rdClk);
    repeat (10) @(negedge wrClk);
    if (!holdM) markIdx = rdIdx;
  endtask

  task automatic checkFlags(string tag);
    int stored, freeW;
    settle();
    stored = wrIdx - rdIdx;
    freeW  = DEPTH - (wrIdx - markIdx);
    chk({tag, " R3 inReady"},     inReady,     freeW != 0);
    chk({tag, " R5 almostFull"},  almostFull,  expAf(freeW));
    chk({tag, " R4 outReady"},    outReady,    stored != 0);
    chk({tag, " R6 almostEmpty"}, almostEmpty, expAe(stored));
  endtask

  task automatic push(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wrClk);
      while (!inReady) begin wrEn = 0; @(negedge wrClk); end
      wrData = rnd36();
      wrEn = 1;
      wlog[wrIdx & 8191] = wrData;
      wrIdx++;
    end
    @(negedge wrClk) wrEn = 0;
  endtask

  task automatic drain(int n);
    int got = 0;
    while (got < n) begin
      @(negedge rdClk);
      if (outReady) begin
        chk("R2 data order", rdData, wlog[rdIdx & 8191]);
        rdIdx++; got++; rdEn = 1;
      end else rdEn = 0;
    end
    @(negedge rdClk) rdEn = 0;
  endtask

  task automatic cfgLoad(bit sel, int val);
    @(negedge wrClk);
    cfgWrite = 1; cfgSel = sel; wrEn = 1; wrData = DW'(val);
    @(negedge wrClk);
    cfgWrite = 0; wrEn = 0;
  endtask

  task automatic serialLoad(int af, int ae);
    logic [2*AW-1:0] v = {AW'(af), AW'(ae)};
    for (int b = 2*AW-1; b >= 0; b--) begin
      @(negedge wrClk); serEn = 1; serIn = v[b];
    end
    @(negedge wrClk) serEn = 0;
  endtask

  task automatic randomPhase(int cycles, int wp, int rp);
    bit wDone = 0;
    fork
      begin
        for (int c = 0; c < cycles; c++) begin
          @(negedge wrClk);
          wrData = rnd36();
          wrEn = ($urandom % 100) < wp;
          if (wrEn && inReady) begin wlog[wrIdx & 8191] = wrData; wrIdx++; end
        end
        @(negedge wrClk) wrEn = 0;
        wDone = 1;
      end
      begin
        while (!(wDone && rdIdx == wrIdx)) begin
          bit r;
          @(negedge rdClk);
          r = ($urandom % 100) < rp;
          if (r && outReady) begin
            chk("R2 random order", rdData, wlog[rdIdx & 8191]);
            rdIdx++;
          end
          rdEn = r;
        end
        @(negedge rdClk) rdEn = 0;
      end
    join
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    int n;
    void'($urandom(32'd7321));
    // R1 reset state
    repeat (4) @(negedge wrClk);
    chk("R1 inReady in reset", inReady, 0);
    chk("R1 outReady in reset", outReady, 0);
    chk("R1 almostEmpty in reset", almostEmpty, 1);
    chk("R1 almostFull in reset", almostFull, 0);
    rstN = 1;
    @(negedge wrClk);
    chk("R1 inReady one edge after release", inReady, 0);
    checkFlags("R1 after reset");

    // R12 first-word latency, R9 default offsets
    @(negedge wrClk);
    wrData = rnd36(); wrEn = 1; wlog[wrIdx & 8191] = wrData; wrIdx++;
    @(negedge wrClk) wrEn = 0;
    n = 0;
    while (!outReady && n < 20) begin @(negedge rdClk); n++; end
    chk("R12 outReady latency in window", (n >= 2 && n <= 6), 1);
    push(7);
    checkFlags("R9 stored 8");
    chk("R9 almostEmpty at default 8", almostEmpty, 1);
    push(1);
    checkFlags("R9 stored 9");
    drain(wrIdx - rdIdx);
    checkFlags("R2 drained");

    // R4 rdEn on empty has no effect
    @(negedge rdClk) rdEn = 1;
    repeat (5) @(negedge rdClk);
    rdEn = 0;
    push(1);
    settle();
    chk("R4 word kept after empty reads", outReady, 1);
    chk("R4 data after empty reads", rdData, wlog[rdIdx & 8191]);
    drain(1);

    // R7 parallel offset load, no store
    cfgLoad(1'b0, 3); aeM = 3;
    cfgLoad(1'b1, 5); afM = 5;
    checkFlags("R7 after cfg");
    chk("R7 cfg word not stored", outReady, 0);
    push(3);
    checkFlags("R7 ae=3 stored 3");
    push(1);
    checkFlags("R7 ae=3 stored 4");
    drain(wrIdx - rdIdx);

    // R3/R5 fill to full
    settle();
    push(DEPTH - 6);
    checkFlags("R5 free 6");
    push(1);
    checkFlags("R5 free 5");
    chk("R5 almostFull at free 5", almostFull, 1);
    push(5);
    checkFlags("R3 full");
    chk("R3 inReady low when full", inReady, 0);
    @(negedge wrClk); wrEn = 1; wrData = rnd36();
    repeat (3) @(negedge wrClk);
    wrEn = 0;
    drain(DEPTH);
    checkFlags("R3 extra words dropped");

    // R8 serial load
    serialLoad(10, 2); afM = 10; aeM = 2;
    push(2);
    checkFlags("R8 ae=2 stored 2");
    chk("R8 almostEmpty stored 2", almostEmpty, 1);
    push(1);
    checkFlags("R8 ae=2 stored 3");
    chk("R8 almostEmpty stored 3", almostEmpty, 0);
    drain(wrIdx - rdIdx);

    // R10/R11 replay
    settle();
    @(negedge rdClk) rtHold = 1;
    holdM = 1; markIdx = rdIdx;
    push(12);
    drain(12);
    checkFlags("R10 frame read");
    @(negedge rdClk) rtReplay = 1;
    @(negedge rdClk) rtReplay = 0;
    chk("R10 outReady cleared by replay", outReady, 0);
    rdIdx = markIdx;
    drain(12);
    checkFlags("R11 held frame counted");
    push(DEPTH - 12);
    checkFlags("R11 full from mark");
    chk("R11 inReady low with held frame", inReady, 0);
    @(negedge rdClk) rtHold = 0;
    holdM = 0;
    drain(wrIdx - rdIdx);
    checkFlags("R11 released");

    // random traffic
    randomPhase(3000, 70, 40);
    checkFlags("R2 random fill-heavy");
    randomPhase(3000, 35, 80);
    checkFlags("R2 random drain-heavy");

    finished = 1;
    summary();
  end

endmodule